// File: doc/BRIEF.md
# I2C Sixteen-Pin GPIO Expander

The block is a sixteen-pin general-purpose I/O expander that an I2C master controls as a slave device. The pins form two 8-bit ports. Each port has four registers: a read-only input view, an output latch, a polarity mask and a direction mask. The master selects one of them by sending a command byte after the slave address. Pins whose direction bit is 1 are inputs. Pins whose direction bit is 0 drive the value held in the output latch. Input values pass through the polarity mask before the master reads them.

An active-low interrupt request tells the master that an input pin has changed. The block compares each input-configured pin with a snapshot taken when the port was last read. The request goes away when the master reads the port, or when the pin goes back to its snapshot value. SCL and SDA are sampled with the system clock, and the block pulls SDA low by asserting a drive-enable, which suits an open-drain pad. Three address-select inputs set the low bits of the slave address, so eight of these blocks can share one bus.

Top module: `gpio_expander_i2c`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal {4'b0100, addr_sel[2:0]}; bit 0 of that byte is 1 for a read. For any other address the block leaves SDA released and ignores the bus until the next START.
- R2: A command byte selects the register: 0/1 input, 2/3 output, 4/5 polarity, 6/7 direction, with the even code for port 0 (pins 7:0) and the odd code for port 1 (pins 15:8). Command values above 7 are not acknowledged.
- R3: After each data byte, read or written, the register pointer moves to the other register of the same pair (bit 0 of the pointer inverts). This lets the master move both ports in one transfer.
- R4: Reading an input register returns the synchronized pin value XOR the polarity register for that port.
- R5: pin_oe[i] is 1 exactly when direction bit i is 0, and pin_out carries the output registers.
- R6: After reset all direction bits are 1, the output registers are all ones and the polarity registers are all zeros. As a result pin_oe is 0, pin_out is 16'hFFFF and irq_n is 1.
- R7: irq_n goes low when any input-configured pin differs from its snapshot. Changes on output-configured pins do not assert it.
- R8: Reading an input register refreshes that port's snapshot, which clears the interrupt the port caused. A pin that returns to its snapshot value also clears it.
- R9: Writes to command codes 0 and 1 are acknowledged and change no register.
- R10: Read data goes out MSB first. A master NACK ends the read, and the block then releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock from the pad |
| sda_i | input | 1 | Bus data from the pad |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 3 | Low three bits of the slave address |
| pin_in | input | 16 | Pad input values |
| pin_out | output | 16 | Pad output values |
| pin_oe | output | 16 | Pad output enables, 1 drives |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench reads an odd register first and expects the pair to wrap 3 then 2. A design whose pointer counts upward would return the polarity register instead. It toggles pins that are configured as outputs and expects no interrupt, which catches a change detector that ignores direction. It also returns a pin to its snapshot value and expects the request to drop, and it reads a single port to clear its own interrupt. It sends command 8, a wrong address and a changed addr_sel, and expects no acknowledge for each. It writes the read-only input register and expects the read-back to be unchanged, which catches a design that stores that write.

// File: rtl/gpio_expander_i2c.sv
module gpio_expander_i2c #(
  parameter logic [3:0] ADDR_HI = 4'b0100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  addr_sel,
  input  logic [15:0] pin_in,
  output logic [15:0] pin_out,
  output logic [15:0] pin_oe,
  output logic        irq_n
);
  localparam logic [2:0] ST_IDLE = 3'd0, ST_ADDR = 3'd1, ST_CMD = 3'd2,
                         ST_WR = 3'd3, ST_RD = 3'd4, ST_SKIP = 3'd5;

  logic [2:0]  scl_q, sda_q, state, ptr;
  logic [15:0] pin_m, pin_s, in_lat, out_r, pol_r, cfg_r, sel16;
  logic [3:0]  bitcnt;
  logic [7:0]  sreg, rd_byte;
  logic [1:0]  arm;
  logic        mnack;

  wire scl_rise = scl_q[1] & ~scl_q[2];
  wire scl_fall = ~scl_q[1] & scl_q[2];
  wire start_c  = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
  wire stop_c   = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
  wire active   = (state != ST_IDLE) && (state != ST_SKIP);
  wire at8      = scl_fall && active && bitcnt == 4'd8;
  wire at9      = scl_fall && active && bitcnt == 4'd9;
  wire do_wr    = at8 && state == ST_WR && !start_c && !stop_c;
  wire do_load  = at9 && !start_c && !stop_c &&
                  ((state == ST_ADDR && sreg[0]) || (state == ST_RD && !mnack));
  wire [3:0] bsel = {ptr[0], 3'b000};

  always_comb begin
    case (ptr[2:1])
      2'd0:    sel16 = pin_s ^ pol_r;
      2'd1:    sel16 = out_r;
      2'd2:    sel16 = pol_r;
      default: sel16 = cfg_r;
    endcase
    rd_byte = ptr[0] ? sel16[15:8] : sel16[7:0];
  end

  assign pin_out = out_r;
  assign pin_oe  = ~cfg_r;
  assign irq_n   = !(arm == 2'd3 && |((pin_s ^ in_lat) & cfg_r));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1; sda_q <= '1; pin_m <= '0; pin_s <= '0; in_lat <= '0;
      out_r <= '1; pol_r <= '0; cfg_r <= '1; state <= ST_IDLE; ptr <= '0;
      bitcnt <= '0; sreg <= '0; arm <= '0; mnack <= 1'b0; sda_oe <= 1'b0;
    end else begin
      scl_q <= {scl_q[1:0], scl_i};
      sda_q <= {sda_q[1:0], sda_i};
      pin_m <= pin_in;
      pin_s <= pin_m;
      if (arm != 2'd3) begin
        arm    <= arm + 2'd1;
        in_lat <= pin_s;
      end
      if (start_c) begin
        state <= ST_ADDR; bitcnt <= '0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        state <= ST_IDLE; sda_oe <= 1'b0;
      end else if (scl_rise && active) begin
        if (bitcnt < 4'd8 && state != ST_RD) sreg <= {sreg[6:0], sda_q[1]};
        if (bitcnt == 4'd8) mnack <= sda_q[1];
        bitcnt <= bitcnt + 4'd1;
      end else if (scl_fall && active) begin
        if (bitcnt == 4'd8) begin
          case (state)
            ST_ADDR: if (sreg[7:1] == {ADDR_HI, addr_sel}) sda_oe <= 1'b1;
                     else state <= ST_SKIP;
            ST_CMD:  if (sreg < 8'd8) begin sda_oe <= 1'b1; ptr <= sreg[2:0]; end
                     else state <= ST_SKIP;
            ST_WR:   begin sda_oe <= 1'b1; ptr[0] <= ~ptr[0]; end
            default: begin sda_oe <= 1'b0; ptr[0] <= ~ptr[0]; end
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt <= '0;
          sda_oe <= 1'b0;
          case (state)
            ST_ADDR: state <= sreg[0] ? ST_RD : ST_CMD;
            ST_CMD:  state <= ST_WR;
            ST_RD:   if (mnack) state <= ST_SKIP;
            default: ;
          endcase
          if (do_load) begin
            sreg   <= rd_byte;
            sda_oe <= ~rd_byte[7];
            if (ptr[2:1] == 2'd0) in_lat[bsel +: 8] <= pin_s[bsel +: 8];
          end
        end else if (state == ST_RD) begin
          sda_oe <= ~sreg[3'd7 - bitcnt[2:0]];
        end
      end
      if (do_wr) begin
        case (ptr[2:1])
          2'd1:    out_r[bsel +: 8] <= sreg;
          2'd2:    pol_r[bsel +: 8] <= sreg;
          2'd3:    cfg_r[bsel +: 8] <= sreg;
          default: ;
        endcase
      end
    end
  end
endmodule

module gpio_expander_i2c_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  st,
  input logic        sda_oe,
  input logic        scl_s,
  input logic [15:0] pin_oe,
  input logic        irq_n,
  input logic        wr_hit
);
  AST_IDLE_SDA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (st == 3'd0) |-> !sda_oe); // R1
  AST_OE_HELD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !wr_hit |=> $stable(pin_oe)); // R5
  AST_IRQ_QUIET_ALL_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n) (pin_oe == 16'hFFFF) |-> irq_n); // R7
  AST_SDA_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sda_oe) |-> !$past(scl_s)); // R10
endmodule

bind gpio_expander_i2c gpio_expander_i2c_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .sda_oe(sda_oe), .scl_s(scl_q[1]),
  .pin_oe(pin_oe), .irq_n(irq_n), .wr_hit(do_wr)
);

// File: tb/gpio_expander_i2c_bench.sv
`timescale 1ns/1ps
module gpio_expander_i2c_bench;
  localparam int Q = 10;
  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1;
  logic [2:0]  addr_sel = 3'b101;
  logic [15:0] pin_in = 16'h0000;
  logic        sda_oe, irq_n;
  logic [15:0] pin_out, pin_oe;
  wire sda_line = m_sda & ~sda_oe;
  int tests = 0, fails = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$], got_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  gpio_expander_i2c u_gpio_expander_i2c (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_n(irq_n));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
  endtask

  task automatic tx(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0;
    end
    wq(2); m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q);
    ack = (sda_line == 1'b0);
    wq(Q); m_scl = 1'b0; wq(2);
  endtask

  task automatic rx(input bit last, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_line; wq(Q); m_scl = 1'b0;
    end
    wq(2); m_sda = last; wq(Q); m_scl = 1'b1; wq(2 * Q); m_scl = 1'b0; wq(2); m_sda = 1'b1;
  endtask

  task automatic wr(input logic [7:0] cmd, input int n, input logic [7:0] d0, input logic [7:0] d1);
    bit ack;
    i2c_start;
    tx({4'b0100, addr_sel, 1'b0}, ack); chk("R1 address ack", ack, 1);
    tx(cmd, ack); chk("R2 command ack", ack, 1);
    tx(d0, ack); chk("R3 data ack", ack, 1);
    if (n > 1) begin tx(d1, ack); chk("R3 second data ack", ack, 1); end
    i2c_stop;
  endtask

  task automatic rd(input logic [7:0] cmd, input int n, input logic [7:0] e0, input logic [7:0] e1, input string req);
    bit ack;
    logic [7:0] b;
    i2c_start;
    tx({4'b0100, addr_sel, 1'b0}, ack); chk("R1 address ack", ack, 1);
    tx(cmd, ack); chk("R2 command ack", ack, 1);
    i2c_start;
    tx({4'b0100, addr_sel, 1'b1}, ack); chk("R1 read address ack", ack, 1);
    exp_q.push_back(e0); req_q.push_back(req);
    rx(n == 1, b); got_q.push_back(b);
    if (n > 1) begin
      exp_q.push_back(e1); req_q.push_back(req);
      rx(1'b1, b); got_q.push_back(b);
    end
    i2c_stop;
    chk("R10 sda released after nack", sda_oe, 0);
  endtask

  initial begin : monitor
    forever begin
      wait (got_q.size() > 0);
      chk(req_q.pop_front(), got_q.pop_front(), exp_q.pop_front());
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : driver
    bit ack;
    wq(10); rst_n = 1'b1; wq(10);
    chk("R6 pin_oe after reset", pin_oe, 16'h0000);
    chk("R6 pin_out after reset", pin_out, 16'hFFFF);
    chk("R6 irq_n after reset", irq_n, 1);
    rd(8'd6, 2, 8'hFF, 8'hFF, "R6 direction reset");
    rd(8'd4, 2, 8'h00, 8'h00, "R6 polarity reset");

    i2c_start; tx(8'h40, ack); i2c_stop;
    chk("R1 wrong address no ack", ack, 0);

    wr(8'd6, 2, 8'hF0, 8'hFF);
    chk("R5 pin_oe from direction", pin_oe, 16'h000F);
    wr(8'd2, 2, 8'hA5, 8'h3C);
    chk("R5 pin_out from output regs", pin_out, 16'h3CA5);
    rd(8'd3, 2, 8'h3C, 8'hA5, "R3 pointer wraps 3 to 2");

    i2c_start; tx({4'b0100, addr_sel, 1'b0}, ack); tx(8'h08, ack); i2c_stop;
    chk("R2 command 8 no ack", ack, 0);

    wr(8'd4, 2, 8'h0F, 8'hAA);
    pin_in = 16'h3C5A; wq(10);
    chk("R7 irq on input change", irq_n, 0);
    rd(8'd0, 2, 8'h55, 8'h96, "R4 input xor polarity");
    wq(5);
    chk("R8 irq cleared by read", irq_n, 1);

    pin_in = pin_in ^ 16'h0001; wq(10);
    chk("R7 output pin change ignored", irq_n, 1);
    pin_in = pin_in ^ 16'h1000; wq(10);
    chk("R7 irq on port1 change", irq_n, 0);
    pin_in = pin_in ^ 16'h1000; wq(10);
    chk("R8 irq cleared on return", irq_n, 1);
    pin_in = pin_in ^ 16'h0200; wq(10);
    chk("R7 irq on bit 9", irq_n, 0);
    rd(8'd1, 1, pin_in[15:8] ^ 8'hAA, 8'h00, "R4 port1 single read");
    wq(5);
    chk("R8 irq cleared by port1 read", irq_n, 1);

    wr(8'd0, 1, 8'h00, 8'h00);
    rd(8'd0, 1, pin_in[7:0] ^ 8'h0F, 8'h00, "R9 input write ignored");
    chk("R9 outputs unchanged", pin_out, 16'h3CA5);

    addr_sel = 3'b000; wq(5);
    i2c_start; tx(8'h4A, ack); i2c_stop;
    chk("R1 old address rejected", ack, 0);
    i2c_start; tx(8'h40, ack); i2c_stop;
    chk("R1 new address accepted", ack, 1);

    wait (got_q.size() == 0);
    wq(20);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule